// File: doc/BRIEF.md
# Host Port Acknowledge Controller

This block produces the acknowledge/ready handshake for an asynchronous slave port. Through that port an external host reaches on-chip memory and I/O space. The host drives active-high read and write strobes, an address-latch input and two chip selects, one for memory space and one for I/O space. The block brings these pins into the core clock domain through synchronizers. It tracks each access with a small state machine and decides when the access may finish. It bases that decision on three status signals from the datapath: read data present, write buffer full and write in progress. It then drives a single acknowledge pin with a polarity chosen by strap.

Two handshake styles share that pin:
- **Acknowledge style:** the pin idles inactive and goes active only once the access can finish.
- **Ready style:** the pin idles active and drops for as long as the access has to wait.

The style and the polarity at reset come from two strap inputs, which are sampled while reset is held. After reset the host can rewrite the two mode bits of an 8-bit configuration register. The block also tells which addressing scheme the host uses:
- **Latch-enable timing:** the latch pulse arrives without a strobe.
- **Separate address cycles:** the latch is high together with the write strobe.

Every address cycle is acknowledged at once.

Top module: `hpa_ack_ctrl`

## Requirements
- R1: Bit 0 of the configuration register holds the polarity strap as sampled during reset (1 = active-high pin). Configuration writes never change it.
- R2: On reset, configuration bit 7 reads 0. Bit 6 reads 1 when the polarity strap equals the acknowledge strap, and 0 when they differ. Bits 5..1 always read 0.
- R3: A configuration write (cfg_we_i high at a clock edge) loads bits 7:6 from cfg_wdata_i[7:6]. The new value is visible on cfg_o after that edge.
- R4: With bit 6 = 0 (acknowledge style), the internal acknowledge is 0 while idle and while waiting. It is 1 once the access can finish, and it returns to 0 after the strobe is removed.
- R5: With bit 6 = 1 (ready style), the internal ready is 1 while idle and once the access can finish. It is 0 while the access waits.
- R6: A read (read strobe, no write strobe) may finish only when rbuf_valid_i = 1 and wr_busy_i = 0.
- R7: A write may finish only when wbuf_full_i = 0 and wr_busy_i = 0.
- R8: An address cycle is chip select, latch and write strobe all high together. It is acknowledged regardless of the datapath status, in either style. A write without the latch still obeys R7.
- R9: The addressing scheme is detected on each rising edge of the latch input. addr_acc_o becomes 1 if the write strobe is high at that moment, and 0 otherwise. It is 0 after reset.
- R10: ack_o equals the internal acknowledge when the polarity bit is 1, and its inverse when the polarity bit is 0.
- R11: A strobe with neither chip select asserted is not an access, and ack_o stays at its idle level.
- R12: A strobe change reaches ack_o on the third rising clock edge after it. Two synchronizer stages and one output register lie in that path. A datapath status change acts on the next edge.
- R13: Bit 7 is reserved. The handshake style follows bit 6 alone, whatever the value of bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset; straps are sampled while it is high |
| strap_pol_i | input | 1 | Polarity strap (1 = active-high acknowledge) |
| strap_ack_i | input | 1 | Acknowledge-pin strap value |
| host_cs_mem_i | input | 1 | Memory-space chip select, active high, asynchronous |
| host_cs_io_i | input | 1 | I/O-space chip select, active high, asynchronous |
| host_rd_i | input | 1 | Read strobe, active high, asynchronous |
| host_wr_i | input | 1 | Write strobe, active high, asynchronous |
| host_ale_i | input | 1 | Address latch input, active high, asynchronous |
| rbuf_valid_i | input | 1 | Read buffer holds valid data |
| wbuf_full_i | input | 1 | Write buffer is full |
| wr_busy_i | input | 1 | A write is in progress in the datapath |
| cfg_we_i | input | 1 | Configuration register write enable |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_o | output | 8 | Configuration register contents |
| addr_acc_o | output | 1 | 1 = separate address cycles detected, 0 = latch-enable timing |
| ack_o | output | 1 | Acknowledge/ready pin, polarity applied |

## Verification
The bench goes through all four strap pairs. For each pair it goes through all four values of the mode bits, so both styles are covered and the reserved bit 7 is shown to have no effect. Under each setting it runs reads and writes against all eight combinations of the datapath status:
- combinations that let an access finish at once separate immediate completion from waiting;
- the blocked cases are then released, which shows the wait ending on the next edge;
- mid-latency samples separate the synchronizer delay from the response itself.

Address cycles are run against a full, busy write path and compared with a plain write under the same status. This tells an address acknowledge apart from a data acknowledge. A latch pulse alone and a strobe without chip select confirm the mode detector and the idle level.

// File: rtl/hpa_pkg.sv
package hpa_pkg;

    localparam int CFG_W   = 8;
    localparam int MODE_HI = 7;
    localparam int MODE_LO = 6;
    localparam int POL_BIT = 0;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_WAIT = 2'd1,
        HS_DONE = 2'd2
    } hs_state_e;

    // synchronized host pins
    typedef struct packed {
        logic cs;
        logic rd;
        logic wr;
        logic ale;
    } host_bus_t;

    // datapath status
    typedef struct packed {
        logic rbuf_valid;
        logic wbuf_full;
        logic wr_busy;
    } dp_status_t;

    // equal straps select ready style
    function automatic logic strap_ready(input logic pol, input logic ack);
        return pol == ack;
    endfunction

    // data access completion rule; write takes precedence over read
    function automatic logic can_finish(input host_bus_t b, input dp_status_t s);
        if (b.wr)
            return !s.wbuf_full && !s.wr_busy;
        return s.rbuf_valid && !s.wr_busy;
    endfunction

endpackage

// File: rtl/hpa_sync.sv
module hpa_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/hpa_cfg.sv
module hpa_cfg
    import hpa_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             strap_pol,
    input  logic             strap_ack,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg,
    output logic             pol,
    output logic             ready_mode
);

    logic [1:0] mode_q;
    logic       pol_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q  <= strap_pol;
            mode_q <= {1'b0, strap_ready(strap_pol, strap_ack)};
        end else if (we) begin
            mode_q <= wdata[MODE_HI:MODE_LO];
        end
    end

    always_comb begin
        cfg                  = '0;
        cfg[MODE_HI:MODE_LO] = mode_q;
        cfg[POL_BIT]         = pol_q;
    end

    assign pol        = pol_q;
    assign ready_mode = mode_q[0];

    AST_POL_HELD: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(pol_q)) else $error("polarity bit changed");   // R1

    AST_MODE_WRITE: assert property (@(posedge clk) disable iff (rst)
        we |=> cfg[MODE_HI:MODE_LO] == $past(wdata[MODE_HI:MODE_LO]))
        else $error("mode bits not loaded");                            // R3

endmodule

// File: rtl/hpa_hs.sv
module hpa_hs
    import hpa_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  host_bus_t  bus,
    input  dp_status_t st,
    input  logic       ready_mode,
    output logic       ack_int,
    output logic       acc_mode
);

    hs_state_e st_q, st_n;
    logic      ack_q, ack_d;
    logic      acc_q, ale_d;
    logic      access, addr_cyc, go;

    assign access   = bus.cs && (bus.rd || bus.wr);
    assign addr_cyc = bus.cs && bus.ale && bus.wr;
    assign go       = addr_cyc || can_finish(bus, st);

    always_comb begin
        st_n = st_q;
        case (st_q)
            HS_IDLE: if (access) st_n = go ? HS_DONE : HS_WAIT;
            HS_WAIT: if (!access) st_n = HS_IDLE;
                     else if (go) st_n = HS_DONE;
            HS_DONE: if (!access) st_n = HS_IDLE;
            default: st_n = HS_IDLE;
        endcase
    end

    assign ack_d = ready_mode ? (st_n != HS_WAIT) : (st_n == HS_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= HS_IDLE;
            ack_q <= ready_mode;
            acc_q <= 1'b0;
            ale_d <= 1'b0;
        end else begin
            st_q  <= st_n;
            ack_q <= ack_d;
            ale_d <= bus.ale;
            if (bus.ale && !ale_d) acc_q <= bus.wr;
        end
    end

    assign ack_int  = ack_q;
    assign acc_mode = acc_q;

    AST_ACK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!ready_mode && !$past(ready_mode) && ack_q) |-> $past(access))
        else $error("ack without strobe");                              // R4

    AST_WAIT_NOT_ACKED: assert property (@(posedge clk) disable iff (rst)
        (st_q == HS_WAIT) |-> !ack_q) else $error("ack while waiting"); // R5

    AST_READ_GATE: assert property (@(posedge clk) disable iff (rst)
        (st_q != HS_DONE && access && !bus.wr && !(st.rbuf_valid && !st.wr_busy))
        |=> st_q != HS_DONE) else $error("read finished early");        // R6

    AST_WRITE_GATE: assert property (@(posedge clk) disable iff (rst)
        (st_q != HS_DONE && bus.cs && bus.wr && !bus.ale && (st.wbuf_full || st.wr_busy))
        |=> st_q != HS_DONE) else $error("write finished early");       // R7

    AST_ADDR_CYCLE_ACK: assert property (@(posedge clk) disable iff (rst)
        addr_cyc |=> st_q == HS_DONE) else $error("address cycle not acked"); // R8

    AST_ACC_DETECT: assert property (@(posedge clk) disable iff (rst)
        (bus.ale && !ale_d && bus.wr) |=> acc_q) else $error("acc mode missed"); // R9

endmodule

// File: rtl/hpa_ack_ctrl.sv
module hpa_ack_ctrl
    import hpa_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             strap_pol_i,
    input  logic             strap_ack_i,
    input  logic             host_cs_mem_i,
    input  logic             host_cs_io_i,
    input  logic             host_rd_i,
    input  logic             host_wr_i,
    input  logic             host_ale_i,
    input  logic             rbuf_valid_i,
    input  logic             wbuf_full_i,
    input  logic             wr_busy_i,
    input  logic             cfg_we_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    output logic [CFG_W-1:0] cfg_o,
    output logic             addr_acc_o,
    output logic             ack_o
);

    localparam int NPIN = 5;

    logic [NPIN-1:0] pins_raw, pins_s;
    host_bus_t       bus;
    dp_status_t      status;
    logic            pol, ready_mode, ack_int;

    assign pins_raw = {host_cs_mem_i, host_cs_io_i, host_rd_i, host_wr_i, host_ale_i};

    hpa_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    always_comb begin
        bus.cs  = pins_s[4] || pins_s[3];
        bus.rd  = pins_s[2];
        bus.wr  = pins_s[1];
        bus.ale = pins_s[0];
        status.rbuf_valid = rbuf_valid_i;
        status.wbuf_full  = wbuf_full_i;
        status.wr_busy    = wr_busy_i;
    end

    hpa_cfg u_cfg (
        .clk        (clk),
        .rst        (rst),
        .strap_pol  (strap_pol_i),
        .strap_ack  (strap_ack_i),
        .we         (cfg_we_i),
        .wdata      (cfg_wdata_i),
        .cfg        (cfg_o),
        .pol        (pol),
        .ready_mode (ready_mode)
    );

    hpa_hs u_hs (
        .clk        (clk),
        .rst        (rst),
        .bus        (bus),
        .st         (status),
        .ready_mode (ready_mode),
        .ack_int    (ack_int),
        .acc_mode   (addr_acc_o)
    );

    assign ack_o = ack_int ^ ~pol;

    AST_PIN_POLARITY: assert property (@(posedge clk) disable iff (rst)
        (ack_o == ack_int) == cfg_o[POL_BIT]) else $error("pin polarity wrong"); // R10

endmodule

// File: tb/tb_hpa_ack_ctrl.sv
module tb_hpa_ack_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strap_pol = 1'b0, strap_ack = 1'b0;
    logic       cs_mem = 0, cs_io = 0, rd = 0, wr = 0, ale = 0;
    logic       rbuf_valid = 0, wbuf_full = 0, wr_busy = 0;
    logic       cfg_we = 0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_o;
    logic       addr_acc, ack;

    int checks = 0;
    int errors = 0;
    logic mode6;

    always #2.5 clk = ~clk;   // 200 MHz

    hpa_ack_ctrl dut (
        .clk(clk), .rst(rst), .strap_pol_i(strap_pol), .strap_ack_i(strap_ack),
        .host_cs_mem_i(cs_mem), .host_cs_io_i(cs_io), .host_rd_i(rd), .host_wr_i(wr),
        .host_ale_i(ale), .rbuf_valid_i(rbuf_valid), .wbuf_full_i(wbuf_full),
        .wr_busy_i(wr_busy), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
        .cfg_o(cfg_o), .addr_acc_o(addr_acc), .ack_o(ack)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // pin level for an internal acknowledge value (R10)
    function automatic logic pin(input logic internal);
        return internal ^ ~strap_pol;
    endfunction

    function automatic logic idle_lvl();
        return pin(mode6);   // R4 idle 0, R5 idle 1
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        step(3);
        rst = 1'b0;
        step(2);
    endtask

    task automatic run_access(input logic is_wr, input logic [2:0] s);
        logic ok;
        rbuf_valid = s[2]; wbuf_full = s[1]; wr_busy = s[0];
        ok = is_wr ? (!s[1] && !s[0]) : (s[2] && !s[0]);
        cs_mem = !s[0]; cs_io = s[0];
        rd = !is_wr; wr = is_wr;
        step(2);
        check("R12 not yet", {7'b0, ack}, {7'b0, idle_lvl()});
        step(1);
        check(is_wr ? "R7 write gate" : "R6 read gate", {7'b0, ack}, {7'b0, pin(ok)});
        if (!ok) begin
            rbuf_valid = 1'b1; wbuf_full = 1'b0; wr_busy = 1'b0;
            step(1);
            check(mode6 ? "R5 ready returns" : "R4 ack after wait", {7'b0, ack}, {7'b0, pin(1'b1)});
        end
        rd = 0; wr = 0; cs_mem = 0; cs_io = 0;
        step(3);
        check(mode6 ? "R5 idle" : "R4 removed", {7'b0, ack}, {7'b0, idle_lvl()});
        rbuf_valid = 0; wbuf_full = 0; wr_busy = 0;
    endtask

    task automatic addr_tests();
        wbuf_full = 1'b1; wr_busy = 1'b1;
        cs_mem = 1; ale = 1; wr = 1;
        step(3);
        check("R8 addr ack", {7'b0, ack}, {7'b0, pin(1'b1)});
        check("R9 acc detect", {7'b0, addr_acc}, 8'd1);
        cs_mem = 0; ale = 0; wr = 0;
        step(3);
        ale = 1;
        step(3);
        check("R9 ale detect", {7'b0, addr_acc}, 8'd0);
        check("R11 ale only idle", {7'b0, ack}, {7'b0, idle_lvl()});
        ale = 0;
        cs_io = 1; wr = 1;
        step(3);
        check("R8 plain write waits", {7'b0, ack}, {7'b0, pin(1'b0)});
        cs_io = 0; wr = 0;
        wbuf_full = 0; wr_busy = 0;
        step(3);
        rbuf_valid = 1; rd = 1;
        step(4);
        check("R11 no chip select", {7'b0, ack}, {7'b0, idle_lvl()});
        rd = 0; rbuf_valid = 0;
        step(3);
    endtask

    initial begin
        for (int sp = 0; sp < 4; sp++) begin
            strap_pol = sp[1]; strap_ack = sp[0];
            do_reset();
            mode6 = (strap_pol == strap_ack);
            check("R2 R1 reset cfg", cfg_o, {1'b0, mode6, 5'b0, strap_pol});
            check("R10 reset pin", {7'b0, ack}, {7'b0, idle_lvl()});
            check("R9 reset scheme", {7'b0, addr_acc}, 8'd0);
            for (int m = 0; m < 4; m++) begin
                cfg_we = 1'b1;
                cfg_wdata = {m[1:0], 5'b11111, ~strap_pol};
                step(1);
                cfg_we = 1'b0;
                cfg_wdata = '0;
                step(1);
                mode6 = m[0];   // R13: bit 7 ignored
                check("R3 mode write", {6'b0, cfg_o[7:6]}, {6'b0, m[1:0]});
                check("R1 pol read-only", {2'b0, cfg_o[5:0]}, {7'b0, strap_pol});
                check("R13 idle level", {7'b0, ack}, {7'b0, idle_lvl()});
                for (int d = 0; d < 2; d++)
                    for (int s = 0; s < 8; s++)
                        run_access(d[0], s[2:0]);
                addr_tests();
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule